// File: doc/BRIEF.md
# Handshaked Byte-Transfer Controller

This block moves bytes between a host and a small peripheral controller over an 8-bit data register. Three active-low lines in a port-B style register frame each byte. The host owns two of them: an in-progress line and an acknowledge line. The block owns a request line. A transfer advances whenever the host flips the in-progress/acknowledge pair, with no separate shift clock.

A direction bit selects one of two transfers. In the first, each byte the host leaves in the data register is captured into an outbound packet store. In the second, a queued reply is handed out one byte per handshake step. When the in-progress line is released, the block reports how many bytes were captured. After every byte event, the block raises an interrupt flag once a fixed delay has passed. If the port is configured fully as outputs, the flag is raised at once. Command decoding, packet contents and the register bus decoder are outside this block: the outbound store and the reply buffer sit next to it, and the block exchanges only an index and a byte with them.

Top module: `hsx_link`

## Requirements
- R1: After reset, `pb_q`, `sr_q` and `pkt_len` read 0, `sr_irq` is 0, and `cap_we` and `pkt_done` are low.
- R2: Port bit 5 is in-progress, bit 4 is acknowledge and bit 3 is request, all active low. An update happens on a port write, a direction write or a reply start. If the update has bit 5 low, the direction is 1, and bits 5:4 differ from the previous port value, the block pulses `cap_we` one cycle later. With that pulse, `cap_byte` carries the data register and `cap_idx` carries the next slot, counting from 0.
- R3: Once `CAP_DEPTH` bytes have been captured, further capture steps store nothing, do not pulse `cap_we` and do not schedule the interrupt.
- R4: If the update has bit 5 low, the direction is 0, and bits 5:4 changed, then while reply bytes remain `sr_q` loads the reply byte at `rpl_idx` and the index advances by one. With no reply byte left, `sr_q` is unchanged.
- R5: The update that loads the final reply byte forces port bit 3 to 1.
- R6: If bit 5 is high in the update and was also high in the previous port value, a change of bit 4 copies the new bit 4 into bit 3 and schedules the interrupt.
- R7: If bit 5 is high in the update but was low in the previous port value, the interrupt is always scheduled. If at least one byte was captured, `pkt_done` pulses with `pkt_len` equal to the count, and the count returns to 0.
- R8: For an update with bit 5 high that is not an R6 acknowledge change, bit 3 is driven to 0 while reply bytes remain.
- R9: When `ddr_all_out` is low, `sr_irq` rises exactly `DELAY_CYC` cycles after the clock edge that registers a scheduling event. When it is high, `sr_irq` rises at that same edge.
- R10: A scheduling event that arrives while a delay is running restarts the delay. This includes the edge on which the delay would have expired. Only one rise of the flag results.
- R11: `irq_ack` clears `sr_irq`. If the delay expires on the same edge, the flag stays set.
- R12: `rpl_start` loads `rpl_len`, sets the reply index to 0, evaluates the handshake rules with the current port value, and schedules the interrupt.
- R13: An update with bit 5 low whose bits 5:4 equal the previous value moves no byte. Only the port value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pb_wr | input | 1 | Port register write strobe |
| pb_wdata | input | 8 | Port value written by the host |
| ctl_wr | input | 1 | Direction bit write strobe |
| ctl_dir | input | 1 | Direction: 1 captures host bytes, 0 hands out reply bytes |
| sr_wr | input | 1 | Data register write strobe |
| sr_wdata | input | 8 | Data register write value |
| ddr_all_out | input | 1 | Port configured fully as outputs: interrupt without delay |
| rpl_start | input | 1 | A new reply packet is ready |
| rpl_len | input | RW | Reply length in bytes, 0 to RPL_DEPTH |
| rpl_byte | input | 8 | Reply byte at `rpl_idx`, from the adjacent buffer |
| irq_ack | input | 1 | Clears the interrupt flag |
| pb_q | output | 8 | Port register including the driven request bit |
| sr_q | output | 8 | Data register |
| rpl_idx | output | RW | Index of the next reply byte |
| cap_we | output | 1 | Captured-byte write pulse |
| cap_idx | output | CW | Slot of the captured byte |
| cap_byte | output | 8 | Captured byte |
| pkt_done | output | 1 | Received packet complete pulse |
| pkt_len | output | CW | Length of the completed packet |
| sr_irq | output | 1 | Data register interrupt flag |

## Verification
Two things can meet on one clock edge. Delay expiry can coincide with a new byte event, and delay expiry can coincide with an acknowledge of the flag. The bench times a second acknowledge-line toggle so that it lands on the exact edge where the running delay ends. It then expects the flag to stay low and to rise a full delay later. In a second run it holds `irq_ack` on the expiry edge and expects the flag to remain set. Randomized sequences of port, direction, data and reply-start operations are compared against a bench model of the handshake rules, with a small capture depth so that overflow occurs often.

// File: rtl/hsx_pkg.sv
package hsx_pkg;
   // Port bit positions; the host-side protocol depends on these positions.
   localparam int REQ_BIT = 3;
   localparam int ACK_BIT = 4;
   localparam int TIP_BIT = 5;

   function automatic logic pair_differs(input logic [7:0] a, input logic [7:0] b);
      return (a[TIP_BIT] != b[TIP_BIT]) || (a[ACK_BIT] != b[ACK_BIT]);
   endfunction
endpackage

// File: rtl/hsx_capture.sv
module hsx_capture #(
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ev,
   input  logic          flush,
   input  logic [7:0]    din,
   output logic          take,
   output logic          we,
   output logic [CW-1:0] slot,
   output logic [7:0]    byte_o,
   output logic          done,
   output logic [CW-1:0] len
);
   logic [CW-1:0] cnt;

   assign take = ev && (cnt != CW'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         we     <= 1'b0;
         slot   <= '0;
         byte_o <= '0;
         done   <= 1'b0;
         len    <= '0;
      end else begin
         we   <= take;
         done <= flush && (cnt != '0);
         if (take) begin
            slot   <= cnt;
            byte_o <= din;
            cnt    <= cnt + CW'(1);
         end else if (flush && (cnt != '0)) begin
            len <= cnt;
            cnt <= '0;
         end
      end
   end
endmodule

// File: rtl/hsx_reply.sv
module hsx_reply #(
   parameter int DEPTH = 16,
   localparam int RW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [RW-1:0] len_in,
   input  logic          step,
   output logic [RW-1:0] idx,
   output logic          pending,
   output logic          adv,
   output logic          last
);
   logic [RW-1:0] idx_q, len_q, len_eff;

   always_comb begin
      idx     = start ? '0 : idx_q;
      len_eff = start ? len_in : len_q;
      pending = idx < len_eff;
      adv     = step && pending;
      last    = adv && ((idx + RW'(1)) >= len_eff);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         len_q <= '0;
      end else begin
         len_q <= len_eff;
         idx_q <= adv ? idx + RW'(1) : idx;
      end
   end
endmodule

// File: rtl/hsx_irq_delay.sv
module hsx_irq_delay #(
   parameter int DELAY_CYC = 15000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sched,
   input  logic immediate,
   input  logic ack,
   output logic flag
);
   generate
      if (DELAY_CYC == 0) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     flag <= 1'b0;
            else if (sched) flag <= 1'b1;
            else if (ack)   flag <= 1'b0;
         end
      end else begin : g_timed
         localparam int DW = $clog2(DELAY_CYC + 1);
         logic [DW-1:0] cnt;
         logic          fire;

         assign fire = !sched && (cnt == DW'(1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               flag <= 1'b0;
            end else begin
               if (sched)            cnt <= immediate ? '0 : DW'(DELAY_CYC);
               else if (cnt != '0)   cnt <= cnt - DW'(1);
               if ((sched && immediate) || fire) flag <= 1'b1;
               else if (ack)                     flag <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/hsx_link.sv
module hsx_link #(
   parameter int CAP_DEPTH = 16,
   parameter int RPL_DEPTH = 16,
   parameter int DELAY_CYC = 15000,
   localparam int CW = $clog2(CAP_DEPTH + 1),
   localparam int RW = $clog2(RPL_DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pb_wr,
   input  logic [7:0]    pb_wdata,
   input  logic          ctl_wr,
   input  logic          ctl_dir,
   input  logic          sr_wr,
   input  logic [7:0]    sr_wdata,
   input  logic          ddr_all_out,
   input  logic          rpl_start,
   input  logic [RW-1:0] rpl_len,
   input  logic [7:0]    rpl_byte,
   input  logic          irq_ack,
   output logic [7:0]    pb_q,
   output logic [7:0]    sr_q,
   output logic [RW-1:0] rpl_idx,
   output logic          cap_we,
   output logic [CW-1:0] cap_idx,
   output logic [7:0]    cap_byte,
   output logic          pkt_done,
   output logic [CW-1:0] pkt_len,
   output logic          sr_irq
);
   import hsx_pkg::*;

   generate
      if (CAP_DEPTH < 1 || RPL_DEPTH < 1 || DELAY_CYC < 0) begin : g_bad_cfg
         $error("hsx_link: depths must be at least 1 and the delay non-negative");
      end
   endgenerate

   logic [7:0] pb_r, sr_r, b_new, b_fin;
   logic       dir_r, dir_new, upd, tip_on, chg, sync_ev, end_ev;
   logic       cap_ev, cap_take, rd_step, rd_adv, rd_last, rd_pend, treq_nxt, sched;

   always_comb begin
      upd     = pb_wr || ctl_wr || rpl_start;
      b_new   = pb_wr ? pb_wdata : pb_r;
      dir_new = ctl_wr ? ctl_dir : dir_r;
      tip_on  = !b_new[TIP_BIT];
      chg     = pair_differs(b_new, pb_r);
      cap_ev  = upd && tip_on && chg && dir_new;
      rd_step = upd && tip_on && chg && !dir_new;
      sync_ev = upd && !tip_on && pb_r[TIP_BIT] && (b_new[ACK_BIT] != pb_r[ACK_BIT]);
      end_ev  = upd && !tip_on && !pb_r[TIP_BIT];

      treq_nxt = b_new[REQ_BIT];
      if (rd_last)                                treq_nxt = 1'b1;
      else if (sync_ev)                           treq_nxt = b_new[ACK_BIT];
      else if (upd && !tip_on && rd_pend)         treq_nxt = 1'b0;

      b_fin          = b_new;
      b_fin[REQ_BIT] = treq_nxt;
      sched = cap_take || rd_adv || sync_ev || end_ev || rpl_start;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pb_r  <= '0;
         sr_r  <= '0;
         dir_r <= 1'b0;
      end else begin
         if (upd)        pb_r <= b_fin;
         dir_r <= dir_new;
         if (rd_adv)     sr_r <= rpl_byte;
         else if (sr_wr) sr_r <= sr_wdata;
      end
   end

   hsx_capture #(.DEPTH(CAP_DEPTH)) u_capture (
      .clk(clk), .rst_n(rst_n), .ev(cap_ev), .flush(end_ev), .din(sr_r),
      .take(cap_take), .we(cap_we), .slot(cap_idx), .byte_o(cap_byte),
      .done(pkt_done), .len(pkt_len)
   );

   hsx_reply #(.DEPTH(RPL_DEPTH)) u_reply (
      .clk(clk), .rst_n(rst_n), .start(rpl_start), .len_in(rpl_len),
      .step(rd_step), .idx(rpl_idx), .pending(rd_pend), .adv(rd_adv),
      .last(rd_last)
   );

   hsx_irq_delay #(.DELAY_CYC(DELAY_CYC)) u_irq (
      .clk(clk), .rst_n(rst_n), .sched(sched), .immediate(ddr_all_out),
      .ack(irq_ack), .flag(sr_irq)
   );

   assign pb_q = pb_r;
   assign sr_q = sr_r;
endmodule

// File: rtl/hsx_link_chk.sv
module hsx_link_chk #(
   parameter int CAP_DEPTH = 16,
   parameter int RPL_DEPTH = 16,
   localparam int CW = $clog2(CAP_DEPTH + 1),
   localparam int RW = $clog2(RPL_DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pb_wr,
   input logic          ctl_wr,
   input logic          sr_wr,
   input logic          rpl_start,
   input logic          irq_ack,
   input logic [7:0]    pb_q,
   input logic [7:0]    sr_q,
   input logic [RW-1:0] rpl_idx,
   input logic          cap_we,
   input logic [CW-1:0] cap_idx,
   input logic          pkt_done,
   input logic [CW-1:0] pkt_len,
   input logic          sr_irq
);
   a_r3_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cap_we |-> (cap_idx < CW'(CAP_DEPTH)));

   a_r7_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |-> (pkt_len != '0));

   a_r2_capture_not_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cap_we, pkt_done}));

   a_r13_port_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(pb_wr || ctl_wr || rpl_start) |-> $stable(pb_q));

   a_r4_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(pb_wr || ctl_wr || rpl_start || sr_wr) |-> $stable(sr_q));

   a_r11_fall_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sr_irq) |-> $past(irq_ack));

   a_r12_start_index: assert property (@(posedge clk) disable iff (!rst_n)
      rpl_start |-> (rpl_idx == '0));
endmodule

bind hsx_link hsx_link_chk #(.CAP_DEPTH(CAP_DEPTH), .RPL_DEPTH(RPL_DEPTH)) u_hsx_link_chk (
   .clk(clk), .rst_n(rst_n), .pb_wr(pb_wr), .ctl_wr(ctl_wr), .sr_wr(sr_wr),
   .rpl_start(rpl_start), .irq_ack(irq_ack), .pb_q(pb_q), .sr_q(sr_q),
   .rpl_idx(rpl_idx), .cap_we(cap_we), .cap_idx(cap_idx), .pkt_done(pkt_done),
   .pkt_len(pkt_len), .sr_irq(sr_irq)
);

// File: tb/test_hsx_link.sv
module test_hsx_link;
   localparam int CAPD = 4;
   localparam int RPLD = 16;
   localparam int DLY  = 12;
   localparam int CW   = $clog2(CAPD + 1);
   localparam int RW   = $clog2(RPLD + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pb_wr = 0, ctl_wr = 0, ctl_dir = 0, sr_wr = 0, ddr_all_out = 0;
   logic rpl_start = 0, irq_ack = 0;
   logic [7:0] pb_wdata = 0, sr_wdata = 0;
   logic [RW-1:0] rpl_len = 0;
   logic [7:0] rpl_byte;
   logic [7:0] pb_q, sr_q, cap_byte;
   logic [RW-1:0] rpl_idx;
   logic cap_we, pkt_done, sr_irq;
   logic [CW-1:0] cap_idx, pkt_len;
   logic [7:0] rbuf [0:RPLD];

   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   assign rpl_byte = rbuf[rpl_idx];

   hsx_link #(.CAP_DEPTH(CAPD), .RPL_DEPTH(RPLD), .DELAY_CYC(DLY)) i_hsx_link (
      .clk(clk), .rst_n(rst_n), .pb_wr(pb_wr), .pb_wdata(pb_wdata),
      .ctl_wr(ctl_wr), .ctl_dir(ctl_dir), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
      .ddr_all_out(ddr_all_out), .rpl_start(rpl_start), .rpl_len(rpl_len),
      .rpl_byte(rpl_byte), .irq_ack(irq_ack), .pb_q(pb_q), .sr_q(sr_q),
      .rpl_idx(rpl_idx), .cap_we(cap_we), .cap_idx(cap_idx), .cap_byte(cap_byte),
      .pkt_done(pkt_done), .pkt_len(pkt_len), .sr_irq(sr_irq)
   );

   // bench model of the handshake rules
   logic [7:0] m_pb = 0, m_sr = 0;
   logic m_dir = 0;
   int m_cnt = 0, m_ridx = 0, m_rlen = 0;
   bit e_we, e_done;
   int e_slot, e_len;
   logic [7:0] e_byte;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model(input bit pbw, input logic [7:0] pbv, input bit cw, input bit cd,
                        input bit rs, input int rl, input bit srw, input logic [7:0] srv);
      logic [7:0] b;
      bit loaded;
      e_we = 0; e_done = 0; loaded = 0;
      b = pbw ? pbv : m_pb;
      if (cw) m_dir = cd;
      if (rs) begin m_ridx = 0; m_rlen = rl; end
      if (pbw || cw || rs) begin
         if (!b[5]) begin
            if (b[5:4] != m_pb[5:4]) begin
               if (m_dir) begin
                  if (m_cnt < CAPD) begin
                     e_we = 1; e_slot = m_cnt; e_byte = m_sr; m_cnt++;
                  end
               end else if (m_ridx < m_rlen) begin
                  m_sr = rbuf[m_ridx]; m_ridx++; loaded = 1;
                  if (m_ridx >= m_rlen) b[3] = 1'b1;
               end
            end
         end else if (m_pb[5] && (b[4] != m_pb[4])) begin
            b[3] = b[4];
         end else begin
            if (!m_pb[5] && m_cnt > 0) begin
               e_done = 1; e_len = m_cnt; m_cnt = 0;
            end
            if (m_ridx < m_rlen) b[3] = 1'b0;
         end
         m_pb = b;
      end
      if (srw && !loaded) m_sr = srv;
   endtask

   // drives at the current falling edge, compares one cycle later
   task automatic op(input bit pbw, input logic [7:0] pbv, input bit cw, input bit cd,
                     input bit rs, input int rl, input bit srw, input logic [7:0] srv);
      model(pbw, pbv, cw, cd, rs, rl, srw, srv);
      pb_wr = pbw; pb_wdata = pbv; ctl_wr = cw; ctl_dir = cd;
      rpl_start = rs; rpl_len = RW'(rl); sr_wr = srw; sr_wdata = srv;
      @(negedge clk);
      pb_wr = 0; ctl_wr = 0; rpl_start = 0; sr_wr = 0;
      chk(pb_q == m_pb, "R5 R6 R8 R13", "port", pb_q, m_pb);
      chk(sr_q == m_sr, "R4", "data", sr_q, m_sr);
      chk(cap_we == e_we, "R2 R3", "cap_we", cap_we, e_we);
      if (e_we) begin
         chk(int'(cap_idx) == e_slot, "R2", "cap_idx", cap_idx, e_slot);
         chk(cap_byte == e_byte, "R2", "cap_byte", cap_byte, e_byte);
      end
      chk(pkt_done == e_done, "R7", "pkt_done", pkt_done, e_done);
      if (e_done) chk(int'(pkt_len) == e_len, "R7", "pkt_len", pkt_len, e_len);
   endtask

   task automatic wpb(input logic [7:0] v); op(1, v, 0, 0, 0, 0, 0, 0); endtask
   task automatic wdir(input bit d); op(0, 0, 1, d, 0, 0, 0, 0); endtask
   task automatic wsr(input logic [7:0] v); op(0, 0, 0, 0, 0, 0, 1, v); endtask
   task automatic rstart(input int l); op(0, 0, 0, 0, 1, l, 0, 0); endtask
   task automatic waitn(input int n); repeat (n) @(negedge clk); endtask
   task automatic ack();
      irq_ack = 1; @(negedge clk); irq_ack = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i <= RPLD; i++) rbuf[i] = 8'h00;
      void'($urandom(32'd4711));
      waitn(3);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(pb_q == 0, "R1", "port", pb_q, 0);
      chk(sr_q == 0 && pkt_len == 0, "R1", "data/len", sr_q, 0);
      chk(!sr_irq && !cap_we && !pkt_done, "R1", "flags", {sr_irq, cap_we, pkt_done}, 0);

      // R2 capture and R7 end of packet
      wdir(1);
      wpb(8'h38);
      wsr(8'hA5);
      wpb(8'h18);
      chk(cap_we && cap_idx == 0 && cap_byte == 8'hA5, "R2", "first capture", cap_byte, 8'hA5);
      wsr(8'h3C);
      wpb(8'h08);
      chk(cap_we && cap_idx == 1 && cap_byte == 8'h3C, "R2", "second capture", cap_byte, 8'h3C);
      wpb(8'h0A); // R13 pair unchanged
      chk(!cap_we && pb_q == 8'h0A, "R13", "no step", pb_q, 8'h0A);
      wpb(8'h38);
      chk(pkt_done && pkt_len == 2, "R7", "packet length", pkt_len, 2);

      // R3 store full
      wpb(8'h18); wpb(8'h08); wpb(8'h18); wpb(8'h08);
      waitn(DLY + 2); ack();
      wpb(8'h18);
      chk(!cap_we, "R3", "no store when full", cap_we, 0);
      waitn(DLY + 2);
      chk(!sr_irq, "R3", "no interrupt when full", sr_irq, 0);
      wpb(8'h38);
      chk(pkt_done && pkt_len == CW'(CAPD), "R7", "full packet", pkt_len, CAPD);

      // R12 reply start, R8 request low, R4 R5 reply
      wdir(0);
      waitn(DLY + 2); ack();
      rbuf[0] = 8'h11; rbuf[1] = 8'h22; rbuf[2] = 8'h33;
      rstart(3);
      chk(pb_q == 8'h30 && rpl_idx == 0, "R8 R12", "pending request", pb_q, 8'h30);
      waitn(DLY);
      chk(sr_irq, "R12", "start schedules", sr_irq, 1);
      wpb(8'h10);
      chk(sr_q == 8'h11, "R4", "reply 0", sr_q, 8'h11);
      wpb(8'h00);
      chk(sr_q == 8'h22, "R4", "reply 1", sr_q, 8'h22);
      wpb(8'h10);
      chk(sr_q == 8'h33 && pb_q == 8'h18, "R5", "last reply", pb_q, 8'h18);
      wpb(8'h00);
      chk(sr_q == 8'h33 && pb_q == 8'h00, "R4", "reply exhausted", sr_q, 8'h33);

      // R6 sync
      wpb(8'h38);
      wpb(8'h28);
      chk(pb_q == 8'h20, "R6", "request follows low", pb_q, 8'h20);
      wpb(8'h38);
      chk(pb_q == 8'h38, "R6", "request follows high", pb_q, 8'h38);

      // R9 exact delay
      waitn(DLY + 2); ack();
      chk(!sr_irq, "R11", "ack clears", sr_irq, 0);
      wpb(8'h28);
      waitn(DLY - 1);
      chk(!sr_irq, "R9", "not before delay", sr_irq, 0);
      waitn(1);
      chk(sr_irq, "R9", "at delay", sr_irq, 1);

      // R10 restart on the expiry edge
      ack();
      wpb(8'h38);
      waitn(DLY - 1);
      wpb(8'h28);
      chk(!sr_irq, "R10", "expiry cancelled", sr_irq, 0);
      waitn(DLY - 1);
      chk(!sr_irq, "R10", "restarted window", sr_irq, 0);
      waitn(1);
      chk(sr_irq, "R10", "single rise", sr_irq, 1);

      // R11 set wins over ack
      wpb(8'h38);
      waitn(DLY - 1);
      ack();
      chk(sr_irq, "R11", "set wins", sr_irq, 1);
      ack();
      chk(!sr_irq, "R11", "plain ack", sr_irq, 0);

      // R9 immediate
      waitn(DLY + 2); ack();
      ddr_all_out = 1;
      wpb(8'h28);
      chk(sr_irq, "R9", "immediate", sr_irq, 1);
      ddr_all_out = 0;

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         int k;
         k = int'($urandom_range(0, 9));
         if (k < 7) begin
            wpb(8'($urandom));
         end else if (k == 7) begin
            wdir(1'($urandom));
         end else if (k == 8) begin
            wsr(8'($urandom));
         end else begin
            for (int i = 0; i < RPLD; i++) rbuf[i] = 8'($urandom);
            rstart(int'($urandom_range(0, RPLD)));
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule